// File: doc/BRIEF.md
# Reverse-Conducting Switch Gate Controller

This block is the digital decision logic for one switch of a half-bridge in which the transistor and its freewheeling diode are built on the same silicon. Because the diode's forward drop and stored charge depend on the gate state, the gate cannot simply follow the command with a dead time added. The controller watches three binary inputs from the analog front end: the switching command, a flag that the collector-emitter voltage is low (the diode is carrying current), and a comparator flag that the collector-emitter voltage has gone slightly positive. From these it chooses a three-level gate request and selects the gate resistor path.

A rising command is delayed by a local interlock count. Turn-on is suppressed while the diode conducts, and the gate sits at zero volts instead of the negative rail. When a command edge arrives while the diode conducts, the opposite switch is about to turn on. The block then fires a positive gate pulse through the fast resistor path to remove stored charge. The pulse is shorter than the interlock by a small lock margin. Current reversals are followed in both directions: from diode to transistor the gate is turned on at once, and from transistor to diode the gate is dropped to zero until the next command edge. All durations are parameters counted in clock cycles.

Top module: `rcsw_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in its off state, with gate code 2'b00 (negative) and `fast_path_o` low (nominal resistors). A reset applied during operation takes effect on the next clock edge.
- R2: Every input passes through a two-flop synchronizer. A change on an input is acted on at the third rising clock edge after it is applied; the outputs hold their old value after two edges.
- R3: From the off state, a rising command keeps the gate at 2'b00 for INTERLOCK_CYC cycles after it is acted on. The gate then goes to 2'b10 (positive) with `fast_path_o` low.
- R4: A falling command while the transistor is on returns the gate to 2'b00 on the edge where it is acted on.
- R5: A falling command during the interlock countdown cancels the pending turn-on, and the gate stays at 2'b00.
- R6: A low-voltage flag while the gate is off (idle or counting the interlock) enters diode conduction with gate code 2'b01 (zero). The transistor is not turned on there, even with the command high.
- R7: In diode conduction, any command edge starts a desaturation pulse: gate 2'b10 with `fast_path_o` high for exactly INTERLOCK_CYC minus LOCK_CYC cycles, then gate 2'b00 with `fast_path_o` low.
- R8: In diode conduction with the command high, an asserted positive-voltage flag turns the gate on (2'b10, nominal path) on the edge where it is acted on. This takes priority over a command edge.
- R9: In diode conduction with the command low, the positive-voltage flag has no effect and the gate stays at 2'b01.
- R10: A low-voltage flag while the transistor is on drops the gate to 2'b01. The gate stays there after the flag clears and leaves only on the next command edge, which sends it to 2'b00.
- R11: Gate code 2'b11 is never produced, and `fast_path_o` is high only together with gate code 2'b10.
- R12: During a desaturation pulse, changes on all three inputs are ignored until the pulse has run its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 1 | Switching command, asynchronous |
| vce_low_i | input | 1 | Collector-emitter voltage below the diode threshold, asynchronous |
| vce_pos_i | input | 1 | Collector-emitter voltage slightly positive (comparator), asynchronous |
| gate_lvl_o | output | 2 | Gate level request: 00 negative, 01 zero, 10 positive |
| fast_path_o | output | 1 | 1 selects the fast low-resistance gate path, 0 the nominal on/off resistors |

## Verification
The assertions assume that the analog flags are consistent with the state of the switch. The low-voltage and positive-voltage flags are treated as independent bits. The properties judge the design only on the synchronized values, with priorities as stated in the requirements. The assertions also assume that INTERLOCK_CYC exceeds LOCK_CYC, so that the desaturation pulse is at least one cycle long. The stimulus changes inputs only at falling clock edges and holds each combination long enough for the synchronizers to settle. It includes one case where the low-voltage flag clears on the same cycle that the positive flag rises, one case with every input toggled in the middle of a pulse, and desaturation pulses started by both rising and falling commands.

// File: rtl/rcsw_pkg.sv
package rcsw_pkg;

  typedef enum logic [1:0] {
    GL_NEG  = 2'b00,
    GL_ZERO = 2'b01,
    GL_POS  = 2'b10
  } gate_lvl_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ILOCK,
    ST_ON,
    ST_ONDIODE,
    ST_DIODE,
    ST_DESAT
  } gst_e;

  // pulse length: interlock minus lock margin, never below one cycle
  function automatic int desat_cycles(input int il, input int lk);
    return (il > lk) ? (il - lk) : 1;
  endfunction

  // counter width able to hold value n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic gate_lvl_e gate_of(input gst_e s);
    case (s)
      ST_ON, ST_DESAT:      return GL_POS;
      ST_ONDIODE, ST_DIODE: return GL_ZERO;
      default:              return GL_NEG;
    endcase
  endfunction

  function automatic logic fast_of(input gst_e s);
    return (s == ST_DESAT);
  endfunction

endpackage

// File: rtl/rcsw_sync.sv
module rcsw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [NST-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[NST-2:0], d[b]};
    end
    assign q[b] = chain[NST-1];
  end
endmodule

// File: rtl/rcsw_edge.sv
module rcsw_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sig;
  end
  assign rise = sig & ~prev;
  assign fall = ~sig & prev;
endmodule

// File: rtl/rcsw_timer.sv
module rcsw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  // asserted during the final cycle of a loaded interval
  assign done = (cnt == W'(1));
endmodule

// File: rtl/rcsw_fsm.sv
module rcsw_fsm
  import rcsw_pkg::*;
#(
  parameter int W       = 8,
  parameter int IL_CYC  = 20,
  parameter int DS_CYC  = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_s,
  input  logic         cmd_rise,
  input  logic         cmd_fall,
  input  logic         low_s,
  input  logic         pos_s,
  input  logic         tmr_done,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output gst_e         state,
  output logic [1:0]   gate_lvl,
  output logic         fast
);
  localparam logic [W-1:0] IL_V = W'(IL_CYC);
  localparam logic [W-1:0] DS_V = W'(DS_CYC);

  gst_e nxt;
  logic cmd_edge;
  assign cmd_edge = cmd_rise | cmd_fall;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = IL_V;
    case (state)
      ST_OFF: begin
        if (low_s) nxt = ST_DIODE;
        else if (cmd_rise) begin
          nxt      = ST_ILOCK;
          tmr_load = 1'b1;
        end
      end
      ST_ILOCK: begin
        if (cmd_fall)      nxt = ST_OFF;
        else if (low_s)    nxt = ST_DIODE;
        else if (tmr_done) nxt = ST_ON;
      end
      ST_ON: begin
        if (cmd_fall)   nxt = ST_OFF;
        else if (low_s) nxt = ST_ONDIODE;
      end
      ST_ONDIODE: begin
        if (cmd_edge) nxt = ST_OFF;
      end
      ST_DIODE: begin
        if (pos_s && cmd_s) nxt = ST_ON;
        else if (cmd_edge) begin
          nxt      = ST_DESAT;
          tmr_load = 1'b1;
          tmr_val  = DS_V;
        end
      end
      ST_DESAT: begin
        if (tmr_done) nxt = ST_OFF;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  assign gate_lvl = gate_of(state);
  assign fast     = fast_of(state);
endmodule

// File: rtl/rcsw_gate_ctrl.sv
module rcsw_gate_ctrl
  import rcsw_pkg::*;
#(
  parameter int INTERLOCK_CYC = 2000,
  parameter int LOCK_CYC      = 50,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_i,
  input  logic       vce_low_i,
  input  logic       vce_pos_i,
  output logic [1:0] gate_lvl_o,
  output logic       fast_path_o
);
  localparam int DESAT_CYC = desat_cycles(INTERLOCK_CYC, LOCK_CYC);
  localparam int TW        = cnt_bits(INTERLOCK_CYC);

  logic [2:0]    syn;
  logic          cmd_s, low_s, pos_s;
  logic          cmd_rise, cmd_fall;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  gst_e          state;
  logic          in_diode;

  rcsw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({vce_pos_i, vce_low_i, cmd_i}),
    .q(syn)
  );
  assign cmd_s = syn[0];
  assign low_s = syn[1];
  assign pos_s = syn[2];

  rcsw_edge u_edge (
    .clk(clk), .rst(rst), .sig(cmd_s), .rise(cmd_rise), .fall(cmd_fall)
  );

  rcsw_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  rcsw_fsm #(.W(TW), .IL_CYC(INTERLOCK_CYC), .DS_CYC(DESAT_CYC)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_s(cmd_s), .cmd_rise(cmd_rise), .cmd_fall(cmd_fall),
    .low_s(low_s), .pos_s(pos_s), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state),
    .gate_lvl(gate_lvl_o), .fast(fast_path_o)
  );

  assign in_diode = (state == ST_DIODE);
endmodule

// File: rtl/rcsw_gate_chk.sv
module rcsw_gate_chk #(
  parameter int DESAT_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] gate_lvl,
  input logic       fast,
  input logic       cmd_s,
  input logic       cmd_rise,
  input logic       cmd_fall,
  input logic       low_s,
  input logic       pos_s,
  input logic       in_diode
);
  localparam int FW = (DESAT_CYC < 2) ? 2 : $clog2(DESAT_CYC + 2);
  logic [FW-1:0] fast_len;

  always_ff @(posedge clk) begin
    if (rst)       fast_len <= '0;
    else if (fast) fast_len <= fast_len + 1'b1;
    else           fast_len <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (gate_lvl == 2'b00 && !fast));

  // R3
  turn_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_lvl) == 2'b00 && gate_lvl == 2'b10 && !fast) |-> $past(cmd_s));

  // R4
  turn_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_fall && gate_lvl == 2'b10 && !fast) |=> (gate_lvl == 2'b00));

  // R5
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_fall && gate_lvl == 2'b00 && !low_s) |=> (gate_lvl == 2'b00));

  // R6
  diode_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_lvl == 2'b00 && low_s && !cmd_fall) |=> (gate_lvl == 2'b01));

  // R7
  desat_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fast) |-> (fast_len == FW'(DESAT_CYC)));

  // R7
  desat_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fast) |-> ($past(gate_lvl) == 2'b01));

  // R8
  zero_cross_on_chk: assert property (@(posedge clk) disable iff (rst)
    (in_diode && pos_s && cmd_s) |=> (gate_lvl == 2'b10 && !fast));

  // R9
  pos_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (in_diode && pos_s && !cmd_s && !cmd_fall) |=> (gate_lvl == 2'b01));

  // R10
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_lvl == 2'b01 && !in_diode && !cmd_rise && !cmd_fall) |=> (gate_lvl == 2'b01));

  // R11
  no_code3_chk: assert property (@(posedge clk) disable iff (rst)
    gate_lvl != 2'b11);

  // R11
  fast_pos_chk: assert property (@(posedge clk) disable iff (rst)
    fast |-> (gate_lvl == 2'b10));
endmodule

bind rcsw_gate_ctrl rcsw_gate_chk #(.DESAT_CYC(DESAT_CYC)) chk_i (
  .clk(clk), .rst(rst), .gate_lvl(gate_lvl_o), .fast(fast_path_o),
  .cmd_s(cmd_s), .cmd_rise(cmd_rise), .cmd_fall(cmd_fall),
  .low_s(low_s), .pos_s(pos_s), .in_diode(in_diode)
);

// File: tb/rcsw_gate_ctrl_tb.sv
module rcsw_gate_ctrl_tb_top;
  localparam int IL = 20;
  localparam int LK = 4;
  localparam int DS = IL - LK;   // 16-cycle pulse

  localparam logic [1:0] NEG = 2'b00, ZER = 2'b01, POS = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd = 1'b0, vlow = 1'b0, vpos = 1'b0;
  logic [1:0] gate;
  logic fast;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rcsw_gate_ctrl #(.INTERLOCK_CYC(IL), .LOCK_CYC(LK)) dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd), .vce_low_i(vlow), .vce_pos_i(vpos),
    .gate_lvl_o(gate), .fast_path_o(fast)
  );

  typedef struct packed {
    logic       c;
    logic       l;
    logic       p;
    logic [7:0] wt;
    logic [1:0] g;
    logic       f;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,8'd2, NEG,1'b0,4'd2},  // R2 not yet acted on
    '{1'b1,1'b0,1'b0,8'd20,NEG,1'b0,4'd3},  // R3 last interlock cycle
    '{1'b1,1'b0,1'b0,8'd1, POS,1'b0,4'd3},  // R3 on after interlock
    '{1'b0,1'b0,1'b0,8'd2, POS,1'b0,4'd2},  // R2 fall not yet seen
    '{1'b0,1'b0,1'b0,8'd1, NEG,1'b0,4'd4},  // R4 off
    '{1'b1,1'b0,1'b0,8'd10,NEG,1'b0,4'd5},  // R5 counting
    '{1'b0,1'b0,1'b0,8'd30,NEG,1'b0,4'd5},  // R5 cancelled
    '{1'b0,1'b1,1'b0,8'd3, ZER,1'b0,4'd6},  // R6 diode from idle
    '{1'b0,1'b1,1'b1,8'd5, ZER,1'b0,4'd9},  // R9 pos flag, cmd low
    '{1'b0,1'b1,1'b0,8'd2, ZER,1'b0,4'd9},  // R9
    '{1'b1,1'b1,1'b0,8'd3, POS,1'b1,4'd7},  // R7 pulse on rising cmd
    '{1'b0,1'b0,1'b1,8'd15,POS,1'b1,4'd12}, // R12 inputs ignored
    '{1'b0,1'b0,1'b0,8'd1, NEG,1'b0,4'd7},  // R7 pulse ends
    '{1'b1,1'b0,1'b0,8'd23,POS,1'b0,4'd3},  // R3
    '{1'b1,1'b1,1'b0,8'd3, ZER,1'b0,4'd10}, // R10 drop to zero
    '{1'b1,1'b0,1'b0,8'd10,ZER,1'b0,4'd10}, // R10 holds
    '{1'b0,1'b0,1'b0,8'd3, NEG,1'b0,4'd10}, // R10 cmd edge
    '{1'b1,1'b0,1'b0,8'd5, NEG,1'b0,4'd3},  // R3 counting
    '{1'b1,1'b1,1'b0,8'd3, ZER,1'b0,4'd6},  // R6 diode during interlock
    '{1'b1,1'b1,1'b0,8'd30,ZER,1'b0,4'd6},  // R6 turn-on suppressed
    '{1'b1,1'b0,1'b1,8'd3, POS,1'b0,4'd8},  // R8 zero crossing
    '{1'b0,1'b0,1'b0,8'd3, NEG,1'b0,4'd4},  // R4
    '{1'b1,1'b0,1'b0,8'd5, NEG,1'b0,4'd3},  // R3
    '{1'b1,1'b1,1'b0,8'd3, ZER,1'b0,4'd6},  // R6
    '{1'b0,1'b1,1'b0,8'd2, ZER,1'b0,4'd2},  // R2
    '{1'b0,1'b1,1'b0,8'd1, POS,1'b1,4'd7},  // R7 pulse on falling cmd
    '{1'b0,1'b1,1'b0,8'd15,POS,1'b1,4'd7},  // R7
    '{1'b0,1'b1,1'b0,8'd1, NEG,1'b0,4'd7},  // R7 end of pulse
    '{1'b0,1'b1,1'b0,8'd1, ZER,1'b0,4'd6}   // R6 re-entry
  };

  task automatic check(input int rq, input logic [1:0] eg, input logic ef);
    checks++;
    if (gate !== eg || fast !== ef) begin
      errors++;
      $display("FAIL R%0d: gate=%b fast=%b expected gate=%b fast=%b",
               rq, gate, fast, eg, ef);
    end
  endtask

  task automatic check_legal();  // R11
    checks++;
    if (gate === 2'b11 || (fast === 1'b1 && gate !== POS)) begin
      errors++;
      $display("FAIL R11: gate=%b fast=%b expected legal code", gate, fast);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, NEG, 1'b0);                      // R1 during reset
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, NEG, 1'b0);                      // R1 after release
    for (int i = 0; i < NV; i++) begin
      cmd = VEC[i].c; vlow = VEC[i].l; vpos = VEC[i].p;
      repeat (int'(VEC[i].wt)) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i].rq), VEC[i].g, VEC[i].f);
      check_legal();
    end
    // R1: reset in the middle of a pulse
    cmd = 1'b1; vlow = 1'b1; vpos = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    check(7, POS, 1'b1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1, NEG, 1'b0);
    cmd = 1'b0; vlow = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    rst = 1'b0;
    repeat (5) @(posedge clk); @(negedge clk);
    check(1, NEG, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule